// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Decode Unit

This block holds a small byte-addressable instruction store and a program counter. On every cycle it reads the bytes at the current PC and decodes one instruction of one to six bytes. The high nibble of the first byte alone sets the length. The block splits the instruction into an operation nibble, a function nibble, two register specifiers and a 32-bit constant. It also reports the address of the next sequential instruction.

Each decoded instruction leaves on a valid/ready stream. `out_valid` is high whenever the unit is running. The PC advances only when `out_ready` accepts a normal instruction. While `out_ready` is low, the PC and every output field hold still, which is how a downstream stage applies back-pressure. Halt, an illegal encoding or an address fault is still handed over once with its status code. After that handover the unit stops and the PC freezes until the next `restart`.

The testbench or a loader fills the store through a plain byte write port. A `restart` pulse then sets the PC and starts decoding. After reset the unit is stopped and `out_valid` is low.

Top module: `fd_fetch_unit`

## Requirements
- R1: After reset, `stopped` is 1 and `out_valid` is 0. Bytes written through `load_en`/`load_addr`/`load_data` become readable by the decoder on the following cycle.
- R2: A `restart` pulse loads `restart_pc` into the PC and clears the stop. From the next cycle `out_valid` is 1 and `out_pc` equals the loaded value.
- R3: `out_opcode` is bits 7:4 of the byte at the PC and `out_func` is bits 3:0.
- R4: Length by opcode: 0x0, 0x1 and 0x9 take 1 byte; 0x2, 0x6, 0xA and 0xB take 2; 0x7 and 0x8 take 5; 0x3, 0x4 and 0x5 take 6.
- R5: For opcodes 0x2 to 0x6, 0xA and 0xB, `out_ra` is bits 7:4 and `out_rb` is bits 3:0 of the second byte. For all other opcodes both fields read 0xF.
- R6: `out_const` is assembled least significant byte first. For 0x7 and 0x8 it comes from bytes 1 to 4. For 0x3 to 0x5 it comes from bytes 2 to 5. For every other opcode it is zero. For example, 50 15 f4 ff ff ff gives 0xfffffff4.
- R7: `out_next_pc` equals `out_pc` plus the length. An accepted instruction with status OK moves the PC to that value on the next cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, the PC holds and `out_valid` stays 1.
- R9: Opcode 0x0 reports status 1 (halt). Once accepted, the unit stops and the PC freezes.
- R10: Status 2 (illegal) is reported for these encodings:
  - an opcode above 0xB;
  - opcode 0x2 or 0x7 with a function above 6;
  - opcode 0x6 with a function above 3.

  Other opcodes accept any function. Once accepted, the unit stops with the PC frozen.
- R11: Status 3 (address fault) is reported when the PC is at or beyond the store depth. It is also reported when a legal instruction's last byte would lie beyond the end. An out-of-range first byte takes priority over the illegal check. Status 0 means a normal instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Byte write strobe into the instruction store |
| load_addr | input | AW | Byte address of the write |
| load_data | input | 8 | Byte written |
| restart | input | 1 | Load `restart_pc` and resume decoding |
| restart_pc | input | PC_W | Start address applied on restart |
| out_valid | output | 1 | A decoded instruction is presented |
| out_ready | input | 1 | Downstream accepts the presented instruction |
| out_pc | output | PC_W | Address of the presented instruction |
| out_opcode | output | 4 | Operation nibble |
| out_func | output | 4 | Function nibble |
| out_ra | output | 4 | First register specifier (0xF if none) |
| out_rb | output | 4 | Second register specifier (0xF if none) |
| out_const | output | 32 | Little-endian constant or destination |
| out_next_pc | output | PC_W | Sequential next address |
| out_stat | output | 2 | 0 OK, 1 halt, 2 illegal, 3 address fault |
| stopped | output | 1 | Unit frozen until restart |

## Verification
The hardest case to reach from the ports is an instruction that begins inside the store but ends past its last byte. It is sensitive to the exact compare against the depth. The bench places 6-byte and 5-byte encodings so that they end exactly on the boundary and one byte past it, and restarts the PC onto them. It also restarts the PC onto the depth itself. Every opcode and function pair is swept so that each illegal/legal border is crossed. After each pair, one handshake shows whether the unit advanced or froze.

// File: rtl/fd_pkg.sv
package fd_pkg;
  localparam int FD_CONST_BYTES = 4;
  localparam int FD_MAX_LEN     = FD_CONST_BYTES + 2;
  localparam int FD_LEN_W       = $clog2(FD_MAX_LEN + 1);

  typedef enum logic [1:0] {
    FD_OK     = 2'd0,
    FD_HALT   = 2'd1,
    FD_BADINS = 2'd2,
    FD_BADADR = 2'd3
  } fd_stat_e;

  localparam logic [3:0] OPC_HALT = 4'h0;
  localparam logic [3:0] OPC_MOVE = 4'h2;
  localparam logic [3:0] OPC_ALU  = 4'h6;
  localparam logic [3:0] OPC_JUMP = 4'h7;
  localparam logic [3:0] OPC_LAST = 4'hB;
  localparam logic [3:0] REG_NONE = 4'hF;

  function automatic logic [FD_LEN_W-1:0] op_length(input logic [3:0] opc);
    case (opc)
      4'h2, 4'h6, 4'hA, 4'hB: op_length = FD_LEN_W'(2);
      4'h7, 4'h8:             op_length = FD_LEN_W'(FD_CONST_BYTES + 1);
      4'h3, 4'h4, 4'h5:       op_length = FD_LEN_W'(FD_MAX_LEN);
      default:                op_length = FD_LEN_W'(1);
    endcase
  endfunction

  function automatic logic has_regbyte(input logic [3:0] opc);
    case (opc)
      4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB: has_regbyte = 1'b1;
      default: has_regbyte = 1'b0;
    endcase
  endfunction

  function automatic logic const_no_reg(input logic [3:0] opc);
    const_no_reg = (opc == 4'h7) || (opc == 4'h8);
  endfunction

  function automatic logic const_after_reg(input logic [3:0] opc);
    const_after_reg = (opc == 4'h3) || (opc == 4'h4) || (opc == 4'h5);
  endfunction

  function automatic logic enc_legal(input logic [3:0] opc, input logic [3:0] fnc);
    if (opc > OPC_LAST)                          enc_legal = 1'b0;
    else if (opc == OPC_MOVE || opc == OPC_JUMP) enc_legal = (fnc <= 4'd6);
    else if (opc == OPC_ALU)                     enc_legal = (fnc <= 4'd3);
    else                                         enc_legal = 1'b1;
  endfunction
endpackage

// File: rtl/fd_bytemem.sv
module fd_bytemem
  import fd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PC_W  = 32,
  parameter int WIN   = FD_MAX_LEN,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [PC_W-1:0]     rd_base,
  output logic [WIN-1:0][7:0] rd_bytes,
  output logic [WIN-1:0]      rd_inrange
);
  localparam logic [PC_W:0] LIMIT = (PC_W+1)'(DEPTH);

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  for (genvar k = 0; k < WIN; k++) begin : g_port
    logic [PC_W:0] addr_k;
    assign addr_k        = {1'b0, rd_base} + (PC_W+1)'(k);
    assign rd_inrange[k] = addr_k < LIMIT;
    assign rd_bytes[k]   = rd_inrange[k] ? store[addr_k[AW-1:0]] : 8'h00;
  end
endmodule

// File: rtl/fd_decode.sv
module fd_decode
  import fd_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int WIN  = FD_MAX_LEN
) (
  input  logic [PC_W-1:0]            pc,
  input  logic [WIN-1:0][7:0]        bytes_in,
  input  logic [WIN-1:0]             inrange,
  output logic [3:0]                 opc,
  output logic [3:0]                 fnc,
  output logic [3:0]                 ra,
  output logic [3:0]                 rb,
  output logic [8*FD_CONST_BYTES-1:0] imm,
  output logic [PC_W-1:0]            next_pc,
  output fd_stat_e                   stat
);
  logic [FD_LEN_W-1:0] len;

  assign opc     = bytes_in[0][7:4];
  assign fnc     = bytes_in[0][3:0];
  assign len     = op_length(opc);
  assign next_pc = pc + PC_W'(len);

  always_comb begin
    if (has_regbyte(opc)) begin
      ra = bytes_in[1][7:4];
      rb = bytes_in[1][3:0];
    end else begin
      ra = REG_NONE;
      rb = REG_NONE;
    end
  end

  always_comb begin
    imm = '0;
    for (int j = 0; j < FD_CONST_BYTES; j++) begin
      if (const_no_reg(opc))         imm[8*j +: 8] = bytes_in[1+j];
      else if (const_after_reg(opc)) imm[8*j +: 8] = bytes_in[2+j];
    end
  end

  always_comb begin
    if (!inrange[0])                 stat = FD_BADADR;
    else if (!enc_legal(opc, fnc))   stat = FD_BADINS;
    else if (!inrange[len - 1'b1])   stat = FD_BADADR;
    else if (opc == OPC_HALT)        stat = FD_HALT;
    else                             stat = FD_OK;
  end
endmodule

// File: rtl/fd_pc_ctrl.sv
module fd_pc_ctrl
  import fd_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic [PC_W-1:0] restart_pc,
  input  logic            ready,
  input  logic [PC_W-1:0] next_pc,
  input  fd_stat_e        stat,
  output logic [PC_W-1:0] pc,
  output logic            stopped
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc      <= '0;
      stopped <= 1'b1;
    end else if (restart) begin
      pc      <= restart_pc;
      stopped <= 1'b0;
    end else if (!stopped && ready) begin
      if (stat == FD_OK) pc      <= next_pc;
      else               stopped <= 1'b1;
    end
  end

  AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pc == $past(restart_pc)) && !stopped); // R2

  AST_ADVANCE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !stopped && ready && stat == FD_OK) |=> (pc == $past(next_pc)) && !stopped); // R7

  AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !stopped && !ready) |=> $stable(pc) && !stopped); // R8

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !stopped && ready && stat == FD_HALT) |=> stopped && $stable(pc)); // R9

  AST_FAULT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !stopped && ready && (stat == FD_BADINS || stat == FD_BADADR))
      |=> stopped && $stable(pc)); // R10

  AST_STOPPED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && stopped) |=> stopped && $stable(pc)); // R9
endmodule

// File: rtl/fd_fetch_unit.sv
module fd_fetch_unit
  import fd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PC_W  = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [AW-1:0]   load_addr,
  input  logic [7:0]      load_data,
  input  logic            restart,
  input  logic [PC_W-1:0] restart_pc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PC_W-1:0] out_pc,
  output logic [3:0]      out_opcode,
  output logic [3:0]      out_func,
  output logic [3:0]      out_ra,
  output logic [3:0]      out_rb,
  output logic [31:0]     out_const,
  output logic [PC_W-1:0] out_next_pc,
  output logic [1:0]      out_stat,
  output logic            stopped
);
  logic [FD_MAX_LEN-1:0][7:0] win_bytes;
  logic [FD_MAX_LEN-1:0]      win_ok;
  fd_stat_e                   dec_stat;
  logic [PC_W-1:0]            pc_q;
  logic                       stop_q;

  fd_bytemem #(.DEPTH(DEPTH), .PC_W(PC_W), .WIN(FD_MAX_LEN), .AW(AW)) u_mem (
    .clk        (clk),
    .wr_en      (load_en),
    .wr_addr    (load_addr),
    .wr_data    (load_data),
    .rd_base    (pc_q),
    .rd_bytes   (win_bytes),
    .rd_inrange (win_ok)
  );

  fd_decode #(.PC_W(PC_W), .WIN(FD_MAX_LEN)) u_dec (
    .pc       (pc_q),
    .bytes_in (win_bytes),
    .inrange  (win_ok),
    .opc      (out_opcode),
    .fnc      (out_func),
    .ra       (out_ra),
    .rb       (out_rb),
    .imm      (out_const),
    .next_pc  (out_next_pc),
    .stat     (dec_stat)
  );

  fd_pc_ctrl #(.PC_W(PC_W)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .restart_pc (restart_pc),
    .ready      (out_ready),
    .next_pc    (out_next_pc),
    .stat       (dec_stat),
    .pc         (pc_q),
    .stopped    (stop_q)
  );

  assign out_pc    = pc_q;
  assign out_stat  = dec_stat;
  assign stopped   = stop_q;
  assign out_valid = !stop_q;

  AST_RESET_STOPPED: assert property (@(posedge clk) !rst_n |=> stopped || $past(restart)); // R1
endmodule

// File: tb/test_fd_fetch_unit.sv
module test_fd_fetch_unit;
  localparam int DEPTH = 64;
  localparam int PC_W  = 32;
  localparam int AW    = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            load_en = 1'b0;
  logic [AW-1:0]   load_addr = '0;
  logic [7:0]      load_data = '0;
  logic            restart = 1'b0;
  logic [PC_W-1:0] restart_pc = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [PC_W-1:0] out_pc;
  logic [3:0]      out_opcode, out_func, out_ra, out_rb;
  logic [31:0]     out_const;
  logic [PC_W-1:0] out_next_pc;
  logic [1:0]      out_stat;
  logic            stopped;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  fd_fetch_unit #(.DEPTH(DEPTH), .PC_W(PC_W), .AW(AW)) i_fd_fetch_unit (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .restart(restart), .restart_pc(restart_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc),
    .out_opcode(out_opcode), .out_func(out_func), .out_ra(out_ra), .out_rb(out_rb),
    .out_const(out_const), .out_next_pc(out_next_pc), .out_stat(out_stat),
    .stopped(stopped)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [7:0] data);
    load_en = 1'b1; load_addr = AW'(addr); load_data = data;
    @(posedge clk); #1;
    load_en = 1'b0;
  endtask

  task automatic go(input logic [PC_W-1:0] p);
    restart = 1'b1; restart_pc = p;
    @(posedge clk); #1;
    restart = 1'b0;
    #2;
  endtask

  task automatic step;
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    #2;
  endtask

  function automatic int exp_len(input int op);
    case (op)
      2, 6, 10, 11: return 2;
      7, 8:         return 5;
      3, 4, 5:      return 6;
      default:      return 1;
    endcase
  endfunction

  function automatic bit exp_legal(input int op, input int fn);
    if (op > 11) return 0;
    if (op == 2 || op == 7) return fn <= 6;
    if (op == 6) return fn <= 3;
    return 1;
  endfunction

  function automatic bit exp_hasreg(input int op);
    return (op >= 2 && op <= 6) || op == 10 || op == 11;
  endfunction

  initial begin
    #(8 * 190000);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] bb [6];
    logic [31:0] ec;
    int base;

    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    chk("R1 stopped after reset", 32'(stopped), 32'd1);
    chk("R1 valid low after reset", 32'(out_valid), 32'd0);

    // R3 R4 R5 R6 R7 R9 R10: sweep every opcode/function pair
    base = 8;
    for (int op = 0; op < 16; op++) begin
      for (int fn = 0; fn < 16; fn++) begin
        bb[0] = 8'((op << 4) | fn);
        for (int k = 1; k < 6; k++) bb[k] = 8'((op * 16 + fn) * 13 + k * 37 + 5);
        for (int k = 0; k < 6; k++) wr(base + k, bb[k]);
        go(32'(base));
        chk("R2 valid after restart", 32'(out_valid), 32'd1);
        chk("R2 pc after restart", out_pc, 32'(base));
        chk("R3 opcode", 32'(out_opcode), 32'(op));
        chk("R3 function", 32'(out_func), 32'(fn));
        chk("R5 ra", 32'(out_ra), exp_hasreg(op) ? 32'(bb[1][7:4]) : 32'hF);
        chk("R5 rb", 32'(out_rb), exp_hasreg(op) ? 32'(bb[1][3:0]) : 32'hF);
        if (op == 7 || op == 8)      ec = {bb[4], bb[3], bb[2], bb[1]};
        else if (op >= 3 && op <= 5) ec = {bb[5], bb[4], bb[3], bb[2]};
        else                         ec = 32'h0;
        chk("R6 constant", out_const, ec);
        chk("R4 R7 next pc", out_next_pc, 32'(base + exp_len(op)));
        if (!exp_legal(op, fn)) chk("R10 illegal status", 32'(out_stat), 32'd2);
        else if (op == 0)       chk("R9 halt status", 32'(out_stat), 32'd1);
        else                    chk("R11 ok status", 32'(out_stat), 32'd0);
        step();
        if (exp_legal(op, fn) && op != 0) begin
          chk("R7 advanced", out_pc, 32'(base + exp_len(op)));
          chk("R7 still valid", 32'(out_valid), 32'd1);
        end else begin
          chk("R9 R10 frozen pc", out_pc, 32'(base));
          chk("R9 R10 stopped", 32'(stopped), 32'd1);
        end
      end
    end

    // R6: negative displacement example
    wr(20, 8'h50); wr(21, 8'h15); wr(22, 8'hf4); wr(23, 8'hff); wr(24, 8'hff); wr(25, 8'hff);
    go(32'd20);
    chk("R6 negative displacement", out_const, 32'hfffffff4);
    chk("R5 ra example", 32'(out_ra), 32'h1);
    chk("R5 rb example", 32'(out_rb), 32'h5);

    // R8: back-pressure holds
    repeat (3) @(posedge clk);
    #3;
    chk("R8 pc held", out_pc, 32'd20);
    chk("R8 valid held", 32'(out_valid), 32'd1);

    // R11: boundary placements
    wr(58, 8'h30); wr(59, 8'hf2); wr(60, 8'hcd); wr(61, 8'hab); wr(62, 8'h00); wr(63, 8'h00);
    go(32'd58);
    chk("R11 six bytes ending at top", 32'(out_stat), 32'd0);
    chk("R6 immediate example", out_const, 32'h0000abcd);
    chk("R5 immediate rb", 32'(out_rb), 32'h2);
    wr(59, 8'h30);
    go(32'd59);
    chk("R11 six bytes past top", 32'(out_stat), 32'd3);
    step();
    chk("R11 fault freezes", 32'(stopped), 32'd1);
    wr(59, 8'h70);
    go(32'd59);
    chk("R11 five bytes ending at top", 32'(out_stat), 32'd0);
    chk("R7 next pc at top", out_next_pc, 32'd64);
    wr(60, 8'h80);
    go(32'd60);
    chk("R11 five bytes past top", 32'(out_stat), 32'd3);
    wr(63, 8'h00);
    go(32'd63);
    chk("R9 halt in last byte", 32'(out_stat), 32'd1);
    go(32'd64);
    chk("R11 first byte out of range", 32'(out_stat), 32'd3);
    wr(63, 8'hc0);
    go(32'd63);
    chk("R10 illegal in last byte", 32'(out_stat), 32'd2);

    // R7 R9: short run with continuous acceptance
    wr(0, 8'h10); wr(1, 8'h60); wr(2, 8'h01);
    wr(3, 8'h70); wr(4, 8'h11); wr(5, 8'h22); wr(6, 8'h33); wr(7, 8'h44);
    wr(8, 8'h00);
    go(32'd0);
    chk("R7 run pc0", out_pc, 32'd0);
    step(); chk("R7 run pc1", out_pc, 32'd1);
    step(); chk("R7 run pc3", out_pc, 32'd3);
    chk("R6 jump destination", out_const, 32'h44332211);
    step(); chk("R7 run pc8", out_pc, 32'd8);
    chk("R9 halt seen", 32'(out_stat), 32'd1);
    step();
    chk("R9 halted", 32'(stopped), 32'd1);
    chk("R9 valid low", 32'(out_valid), 32'd0);
    step();
    chk("R9 pc frozen", out_pc, 32'd8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule